// File: doc/BRIEF.md
# Iterative Restoring Unsigned Divider (32 by 16)

This block divides an unsigned dividend of twice the word width, presented as a high word and a low word, by an unsigned divisor of one word. It returns a one-word quotient and a one-word remainder. The work is spread over many clock cycles, one trial subtraction for each quotient bit. With the default word width of 16, that is a 32-bit dividend divided by a 16-bit divisor. The caller pulses `start` with the operands valid. `busy` stays high while the loop runs. `done` pulses for one cycle when `quot` and `rem` hold the answer.

The divisor may have its top bit set. For this reason each trial subtraction is one bit wider than a word. It takes in the bit that the left shift pushes out of the dividend register, so divisors of 0x8000 and above divide correctly. A quotient that cannot fit in one word is caught before the loop starts: whenever the divisor is not greater than the dividend's high word, including a divisor of zero, the block raises `ovf` and reports `done` on the next cycle. In that case the previous quotient and remainder stay untouched.

The controller is a five-state machine:
- `ST_IDLE` waits for a start. On a start it goes to `ST_SHIFT`, or to `ST_REJECT` when the quotient would not fit.
- `ST_SHIFT` shifts the working register left and forms the wide trial difference. It always goes to `ST_COMMIT`.
- `ST_COMMIT` keeps or discards that difference. It loops back to `ST_SHIFT` while iterations remain, and otherwise moves to `ST_FINISH`.
- `ST_FINISH` and `ST_REJECT` each last one cycle, drive `done`, and return to `ST_IDLE`.

Top module: `udiv_iter`

## Requirements
- R1: After reset `busy`, `done` and `ovf` are 0, and `quot` and `rem` are 0.
- R2: For a start with `dvs` greater than `dvd_hi`, at `done` the outputs satisfy {dvd_hi,dvd_lo} = quot*dvs + rem with rem < dvs, and `ovf` is 0.
- R3: Divisors with the top bit set divide correctly. 0x8000_0000 divided by 0xFFFF gives quotient 0x8000 and remainder 0x8000.
- R4: A division that is not rejected raises `busy` for exactly 2*W cycles, W trial iterations of two cycles each. `done` is high in the cycle after that, that is, 2*W+1 cycles after the clock edge that took `start`.
- R5: When `dvs` <= `dvd_hi` at a start (a zero divisor included), `done` and `ovf` are both high in the very next cycle, and `quot` and `rem` keep their previous values.
- R6: `ovf` stays set until the next start that is accepted and not rejected, which clears it.
- R7: A `start` seen while `busy` is high, or during the `done` cycle, is ignored. The running result, its timing and the idle state that follows are unaffected.
- R8: `done` is a single-cycle pulse and is never high together with `busy`.
- R9: Operands are captured at the accepted start. Changing `dvd_hi`, `dvd_lo` or `dvs` afterwards has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (taken only when idle) |
| dvd_hi | input | W | Upper word of the dividend |
| dvd_lo | input | W | Lower word of the dividend |
| dvs | input | W | Divisor |
| busy | output | 1 | Iteration loop running |
| done | output | 1 | One-cycle completion pulse |
| quot | output | W | Quotient |
| rem | output | W | Remainder |
| ovf | output | 1 | Quotient would not fit; division was rejected |

## Verification
Each of the following faults shows up at `done`, 2*W+1 cycles after the start, or one cycle after it on a rejection:
- A trial difference that is too narrow or kept by mistake gives a wrong `quot` or `rem` at that point.
- An off-by-one iteration count moves the `done` pulse away from cycle 2*W+1.
- A faulty rejection path changes `quot` or `rem` within a single cycle.

A small-word instance is swept over every dividend and divisor combination, and every answer is compared with integer division computed in the bench. A full-width instance covers the large-divisor cases, and starts issued mid-run and in the done cycle.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    // Controller states of the iterative divider
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_COMMIT = 3'd2,
        ST_FINISH = 3'd3,
        ST_REJECT = 3'd4
    } udiv_state_e;

endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic too_big,
    output logic load,
    output logic step,
    output logic commit,
    output logic busy,
    output logic done,
    output logic ovf
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] ITER = CW'(W);

    udiv_state_e state, state_nx;
    logic [CW-1:0] cnt;
    logic          ovf_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = too_big ? ST_REJECT : ST_SHIFT;
            ST_SHIFT:  state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = (cnt == '0) ? ST_FINISH : ST_SHIFT;
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register, iteration counter and sticky overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ovf_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (load)
                cnt <= ITER;
            else if (step)
                cnt <= cnt - 1'b1;
            if (load)
                ovf_q <= 1'b0;
            else if (state == ST_IDLE && start && too_big)
                ovf_q <= 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        commit = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:   load = start && !too_big;
            ST_SHIFT:  begin step = 1'b1; busy = 1'b1; end
            ST_COMMIT: begin commit = 1'b1; busy = 1'b1; end
            ST_FINISH: done = 1'b1;
            ST_REJECT: done = 1'b1;
            default:   ;
        endcase
    end

    assign ovf = ovf_q;

    // a shift step always has at least one iteration left
    assert_iter_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (cnt != '0));

    // the loop ends only after the counter is exhausted
    assert_finish_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> (cnt == '0));

    // a rejection leaves the overflow flag raised
    assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |-> ovf_q);

endmodule

// File: rtl/udiv_path.sv
module udiv_path #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         commit,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic         too_big,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    localparam int DW = 2 * W;

    logic [DW-1:0] acc;    // remainder in the upper word, quotient in the lower
    logic [W-1:0]  dsr;    // captured divisor
    logic [W:0]    trial;  // wide trial difference, top bit is the borrow

    // quotient fits only when the divisor exceeds the high word
    assign too_big = (dvs <= dvd_hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            dsr   <= '0;
            trial <= '0;
        end else if (load) begin
            acc <= {dvd_hi, dvd_lo};
            dsr <= dvs;
        end else if (step) begin
            trial <= acc[DW-1:W-1] - {1'b0, dsr};
            acc   <= {acc[DW-2:0], 1'b0};
        end else if (commit) begin
            if (!trial[W]) begin
                acc[DW-1:W] <= trial[W-1:0];
                acc[0]      <= 1'b1;
            end
        end
    end

    assign rem  = acc[DW-1:W];
    assign quot = acc[W-1:0];

    // partial remainder stays below the divisor after each commit
    assert_rem_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (acc[DW-1:W] < dsr));

    // the freshly shifted-in quotient bit starts at zero
    assert_shift_in_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acc[0] == 1'b0));

endmodule

// File: rtl/udiv_iter.sv
module udiv_iter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         ovf
);

    logic load, step, commit, too_big;

    udiv_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .too_big (too_big),
        .load    (load),
        .step    (step),
        .commit  (commit),
        .busy    (busy),
        .done    (done),
        .ovf     (ovf)
    );

    udiv_path #(.W(W)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .commit  (commit),
        .dvd_hi  (dvd_hi),
        .dvd_lo  (dvd_lo),
        .dvs     (dvs),
        .too_big (too_big),
        .quot    (quot),
        .rem     (rem)
    );

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_reject_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && (dvs <= dvd_hi)) |=> (done && ovf));

    assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> ($stable(quot) && $stable(rem)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || (done && !ovf)));

    assert_accept_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start && (dvs > dvd_hi)) |=> (busy && !ovf));

endmodule

// File: tb/sim_udiv_iter.sv
module sim_udiv_iter;

    localparam int CLK_PERIOD = 10;
    localparam int WA = 16;
    localparam int WB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // full-width instance
    logic          s0 = 1'b0;
    logic [WA-1:0] h0 = '0, l0 = '0, d0 = '0;
    logic          busy0, done0, o0;
    logic [WA-1:0] q0, r0;

    // small-width instance for the exhaustive sweep
    logic          s1 = 1'b0;
    logic [WB-1:0] h1 = '0, l1 = '0, d1 = '0;
    logic          busy1, done1, o1;
    logic [WB-1:0] q1, r1;

    udiv_iter #(.W(WA)) u0 (
        .clk(clk), .rst_n(rst_n), .start(s0), .dvd_hi(h0), .dvd_lo(l0), .dvs(d0),
        .busy(busy0), .done(done0), .quot(q0), .rem(r0), .ovf(o0));

    udiv_iter #(.W(WB)) u1 (
        .clk(clk), .rst_n(rst_n), .start(s1), .dvd_hi(h1), .dvd_lo(l1), .dvs(d1),
        .busy(busy1), .done(done1), .quot(q1), .rem(r1), .ovf(o1));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run0(input logic [WA-1:0] hi, input logic [WA-1:0] lo,
                        input logic [WA-1:0] dv, output int n);
        @(negedge clk);
        h0 = hi; l0 = lo; d0 = dv; s0 = 1'b1;
        @(negedge clk);
        s0 = 1'b0;
        n = 1;
        while (!done0 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run1(input logic [WB-1:0] hi, input logic [WB-1:0] lo,
                        input logic [WB-1:0] dv, output int n);
        @(negedge clk);
        h1 = hi; l1 = lo; d1 = dv; s1 = 1'b1;
        @(negedge clk);
        s1 = 1'b0;
        n = 1;
        while (!done1 && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        int n;
        logic [2*WA-1:0] dd;
        logic [WA-1:0] pq, pr, eq, er;
        logic [WB-1:0] bq, br;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of both instances
        chk(busy0 == 0 && done0 == 0 && o0 == 0, "R1", "flags", {busy0, done0, o0}, 0);
        chk(q0 == 0 && r0 == 0, "R1", "quot/rem", {q0, r0}, 0);
        chk(busy1 == 0 && done1 == 0 && o1 == 0 && q1 == 0 && r1 == 0, "R1", "small",
            {busy1, done1, o1, q1, r1}, 0);

        // R3: divisor with top bit set
        run0(16'h8000, 16'h0000, 16'hFFFF, n);
        chk(q0 == 16'h8000, "R3", "quot", q0, 16'h8000);
        chk(r0 == 16'h8000, "R3", "rem", r0, 16'h8000);
        chk(n == 2 * WA + 1, "R4", "latency", n, 2 * WA + 1);
        chk(o0 == 0, "R2", "ovf", o0, 0);

        // R2/R3: near-maximum quotient with large divisor
        run0(16'hFFFE, 16'hFFFF, 16'hFFFF, n);
        chk(q0 == 16'hFFFF && r0 == 16'hFFFE, "R3", "max quot", {q0, r0}, 32'hFFFF_FFFE);

        // R2: general case
        dd = 32'h1234_5678;
        run0(dd[31:16], dd[15:0], 16'h9ABC, n);
        eq = 16'(dd / 32'h9ABC); er = 16'(dd % 32'h9ABC);
        chk(q0 == eq && r0 == er, "R2", "general", {q0, r0}, {eq, er});

        // R5: divide by zero is rejected, results kept
        pq = q0; pr = r0;
        run0(16'h0000, 16'h0001, 16'h0000, n);
        chk(n == 1 && o0 == 1, "R5", "zero divisor", {n[7:0], o0}, {8'd1, 1'b1});
        chk(q0 == pq && r0 == pr, "R5", "kept", {q0, r0}, {pq, pr});
        // R5: divisor equal to high word
        run0(16'h4000, 16'h0000, 16'h4000, n);
        chk(n == 1 && o0 == 1 && q0 == pq && r0 == pr, "R5", "equal divisor",
            {n[7:0], o0, q0, r0}, {8'd1, 1'b1, pq, pr});
        // R6: flag stays while idle
        repeat (3) @(negedge clk);
        chk(o0 == 1, "R6", "sticky", o0, 1);

        // R6, R7, R9: start mid-run with new operands is ignored
        @(negedge clk);
        h0 = 16'h0003; l0 = 16'h1234; d0 = 16'h0100; s0 = 1'b1;
        @(negedge clk);
        s0 = 1'b0;
        chk(o0 == 0 && busy0 == 1, "R6", "cleared on accept", {o0, busy0}, 2'b01);
        n = 1;
        while (!done0 && n < 200) begin
            @(negedge clk);
            n++;
            if (n == 5) begin
                s0 = 1'b1; h0 = 16'h0000; l0 = 16'h0005; d0 = 16'h0002;
            end
            if (n == 6) begin
                s0 = 1'b0; h0 = 16'hFFFF; d0 = 16'h0001;
            end
        end
        chk(n == 2 * WA + 1, "R7", "latency with stray start", n, 2 * WA + 1);
        chk(q0 == 16'h0312 && r0 == 16'h0034, "R9", "captured operands", {q0, r0},
            32'h0312_0034);

        // R7: start during the done cycle is ignored
        s0 = 1'b1; h0 = 16'h0000; l0 = 16'h0009; d0 = 16'h0002;
        @(negedge clk);
        s0 = 1'b0;
        chk(busy0 == 0 && done0 == 0, "R7", "done-cycle start", {busy0, done0}, 0);
        repeat (2) @(negedge clk);
        chk(busy0 == 0 && q0 == 16'h0312 && r0 == 16'h0034, "R7", "still idle",
            {busy0, q0, r0}, {1'b0, 32'h0312_0034});

        // R8: done is a single pulse
        run0(16'h0000, 16'h0064, 16'h0007, n);
        chk(q0 == 16'd14 && r0 == 16'd2, "R2", "small values", {q0, r0}, {16'd14, 16'd2});
        @(negedge clk);
        chk(done0 == 0 && busy0 == 0, "R8", "pulse length", {done0, busy0}, 0);

        // exhaustive sweep of the small instance: R2, R4, R5, R6
        bq = '0; br = '0;
        for (int hi = 0; hi < (1 << WB); hi++) begin
            for (int lo = 0; lo < (1 << WB); lo++) begin
                for (int dv = 0; dv < (1 << WB); dv++) begin
                    int dd1;
                    dd1 = hi * (1 << WB) + lo;
                    run1(WB'(hi), WB'(lo), WB'(dv), n);
                    if (dv <= hi) begin
                        chk(n == 1 && o1 == 1 && q1 == bq && r1 == br, "R5", "sweep reject",
                            {n[7:0], o1, q1, r1}, {8'd1, 1'b1, bq, br});
                    end else begin
                        chk(n == 2 * WB + 1, "R4", "sweep latency", n, 2 * WB + 1);
                        chk(o1 == 0 && q1 == WB'(dd1 / dv) && r1 == WB'(dd1 % dv), "R2",
                            "sweep result", {o1, q1, r1}, {1'b0, WB'(dd1 / dv), WB'(dd1 % dv)});
                        bq = q1; br = r1;
                    end
                end
            end
        end

        finish_run();
    end

endmodule